// File: doc/BRIEF.md
# Shared DRAM Address Multiplexer

This block forms the address seen by a 64K x 8 dynamic RAM that two masters share: a processor with a 16-bit address, and a video controller with a 14-bit address that two external bank bits extend to 16 bits. The address-enable input picks the owner. High selects the processor. Low selects the video side. A refresh request overrides both and presents an internal 8-bit row counter on the memory lines. The bank bits play no part in a refresh.

The chosen 16-bit address reaches the RAM over 8 shared lines. The low byte is the row and the high byte is the column. The lines switch to the column one dot-clock after the row strobe falls. The block also drives the system address bus. While the video side owns it, only bits 0-11 follow the video address and bits 12-15 read as ones. It provides a separate decoder address that follows the video lines in that phase, so a character ROM can be placed in the video view. Finally it joins 8 bits of main-memory data with 4 bits of color-memory data into a 12-bit video data word.

Top module: `dram_addr_mux`

## Requirements
- R1: With aec_i high and refresh_i low, eff_addr_o, sys_addr_o and dec_addr_o all equal cpu_addr_i, and src_o is 0 (processor).
- R2: With aec_i low and refresh_i low, eff_addr_o equals {bank_i, vid_addr_i}, with bank_i in bits 15:14, and src_o is 1 (video).
- R3: While aec_i is low, sys_addr_o[15:12] is 4'hF and sys_addr_o[11:0] equals vid_addr_i[11:0], so the bus shows only 0xF000-0xFFFF.
- R4: While aec_i is low, dec_addr_o equals {bank_i, vid_addr_i} and not the system bus value.
- R5: With refresh_i high, src_o is 2 (refresh), eff_addr_o is {8'h00, refresh row}, and bank_i has no effect.
- R6: With refresh_i low, dram_ma_o shows eff_addr_o[7:0] (row) until the first clock edge that samples ras_ni low. From that edge until an edge samples ras_ni high, it shows eff_addr_o[15:8] (column).
- R7: With refresh_i high, dram_ma_o shows the refresh row for the whole cycle and never switches to the column.
- R8: The refresh row resets to 0. It increments by one at the clock edge that first samples ras_ni high after a low, if refresh_i is high, and wraps from 255 to 0.
- R9: vid_data_o equals {color_data_i, mem_data_i}, with the color nibble in bits 11:8.
- R10: After reset, dram_ma_o is in row phase and the refresh row is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aec_i | input | 1 | Bus owner: 1 processor, 0 video |
| refresh_i | input | 1 | Current RAM cycle is a refresh |
| ras_ni | input | 1 | Row strobe, active low |
| cpu_addr_i | input | 16 | Processor address |
| vid_addr_i | input | 14 | Video controller address |
| bank_i | input | 2 | External bank bits for the video address |
| mem_data_i | input | 8 | Main memory data byte |
| color_data_i | input | 4 | Color memory nibble |
| sys_addr_o | output | 16 | System address bus value |
| eff_addr_o | output | 16 | Effective RAM address |
| src_o | output | 2 | Source: 0 processor, 1 video, 2 refresh |
| dram_ma_o | output | 8 | Multiplexed RAM address lines |
| dec_addr_o | output | 16 | Address seen by the chip-select decoder |
| vid_data_o | output | 12 | Joined video data word |

## Verification
The assertions check on every cycle the source mapping for the processor, video and refresh cases and the forced-high upper bits on the system bus. They also check the row/column phase against the strobe one edge earlier, the single step of the refresh row after a strobe rise, and the data join. Some behaviours show only in the bench's scenarios, because a one-cycle property cannot see them. Those are the counter's wrap after 256 refreshes, the bank bits having no effect during a refresh, and the column switch landing exactly one edge after the strobe falls.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  typedef enum logic [1:0] {
    SRC_CPU  = 2'd0,
    SRC_VID  = 2'd1,
    SRC_RFSH = 2'd2
  } src_e;
endpackage

// File: rtl/dram_addr_select.sv
module dram_addr_select
  import dram_mux_pkg::*;
#(
  parameter int AW     = 16,
  parameter int VAW    = 14,
  parameter int DIR_W  = 12,
  parameter int RW     = 8,
  localparam int BW    = AW - VAW
) (
  input  logic          aec_i,
  input  logic          refresh_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [VAW-1:0] vid_addr_i,
  input  logic [BW-1:0] bank_i,
  input  logic [RW-1:0] rfsh_row_i,
  output logic [AW-1:0] eff_addr_o,
  output src_e          src_o,
  output logic [AW-1:0] sys_addr_o,
  output logic [AW-1:0] dec_addr_o
);
  logic [AW-1:0] vid_full;
  assign vid_full = {bank_i, vid_addr_i};

  always_comb begin
    if (refresh_i) begin
      // refresh bypasses bank bits, row counter only
      eff_addr_o = {{(AW-RW){1'b0}}, rfsh_row_i};
      src_o      = SRC_RFSH;
    end else if (aec_i) begin
      eff_addr_o = cpu_addr_i;
      src_o      = SRC_CPU;
    end else begin
      eff_addr_o = vid_full;
      src_o      = SRC_VID;
    end
  end

  // upper bus bits float to the pull-up level while video drives
  assign sys_addr_o = aec_i ? cpu_addr_i : {{(AW-DIR_W){1'b1}}, vid_addr_i[DIR_W-1:0]};
  assign dec_addr_o = aec_i ? cpu_addr_i : vid_full;
endmodule

// File: rtl/dram_row_col_mux.sv
module dram_row_col_mux #(
  parameter int AW = 16,
  localparam int MW = AW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          refresh_i,
  input  logic [AW-1:0] eff_addr_i,
  output logic [MW-1:0] ma_o,
  output logic          ras_rise_o
);
  logic ras_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ras_q <= 1'b1;
    else         ras_q <= ras_ni;
  end

  assign ras_rise_o = ras_ni && !ras_q;

  always_comb begin
    if (!ras_q && !refresh_i) ma_o = eff_addr_i[AW-1:MW];
    else                      ma_o = eff_addr_i[MW-1:0];
  end
endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          refresh_i,
  input  logic          ras_rise_i,
  output logic [RW-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      row_o <= '0;
    else if (refresh_i && ras_rise_i) row_o <= row_o + 1'b1;
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int AW     = 16,
  parameter int VAW    = 14,
  parameter int DIR_W  = 12,
  parameter int MDW    = 8,
  parameter int CDW    = 4,
  localparam int BW    = AW - VAW,
  localparam int MW    = AW / 2,
  localparam int VDW   = MDW + CDW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           aec_i,
  input  logic           refresh_i,
  input  logic           ras_ni,
  input  logic [AW-1:0]  cpu_addr_i,
  input  logic [VAW-1:0] vid_addr_i,
  input  logic [BW-1:0]  bank_i,
  input  logic [MDW-1:0] mem_data_i,
  input  logic [CDW-1:0] color_data_i,
  output logic [AW-1:0]  sys_addr_o,
  output logic [AW-1:0]  eff_addr_o,
  output logic [1:0]     src_o,
  output logic [MW-1:0]  dram_ma_o,
  output logic [AW-1:0]  dec_addr_o,
  output logic [VDW-1:0] vid_data_o
);
  import dram_mux_pkg::*;

  src_e          src;
  logic [MW-1:0] rfsh_row;
  logic          ras_rise;

  dram_addr_select #(.AW(AW), .VAW(VAW), .DIR_W(DIR_W), .RW(MW)) u_sel (
    .aec_i      (aec_i),
    .refresh_i  (refresh_i),
    .cpu_addr_i (cpu_addr_i),
    .vid_addr_i (vid_addr_i),
    .bank_i     (bank_i),
    .rfsh_row_i (rfsh_row),
    .eff_addr_o (eff_addr_o),
    .src_o      (src),
    .sys_addr_o (sys_addr_o),
    .dec_addr_o (dec_addr_o)
  );

  dram_row_col_mux #(.AW(AW)) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_ni     (ras_ni),
    .refresh_i  (refresh_i),
    .eff_addr_i (eff_addr_o),
    .ma_o       (dram_ma_o),
    .ras_rise_o (ras_rise)
  );

  dram_refresh_ctr #(.RW(MW)) u_rfsh (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .refresh_i  (refresh_i),
    .ras_rise_i (ras_rise),
    .row_o      (rfsh_row)
  );

  assign src_o      = src;
  assign vid_data_o = {color_data_i, mem_data_i};
endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        aec_i,
  input logic        refresh_i,
  input logic        ras_ni,
  input logic [15:0] cpu_addr_i,
  input logic [13:0] vid_addr_i,
  input logic [1:0]  bank_i,
  input logic [7:0]  mem_data_i,
  input logic [3:0]  color_data_i,
  input logic [15:0] sys_addr_o,
  input logic [15:0] eff_addr_o,
  input logic [1:0]  src_o,
  input logic [7:0]  dram_ma_o,
  input logic [15:0] dec_addr_o,
  input logic [11:0] vid_data_o
);
  p_cpu_map_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aec_i && !refresh_i) |-> (eff_addr_o == cpu_addr_i && src_o == 2'd0 && sys_addr_o == cpu_addr_i));

  p_vid_map_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aec_i && !refresh_i) |-> (eff_addr_o == {bank_i, vid_addr_i} && src_o == 2'd1));

  p_sys_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aec_i |-> (sys_addr_o[15:12] == 4'hF && sys_addr_o[11:0] == vid_addr_i[11:0]));

  p_dec_vid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aec_i |-> (dec_addr_o == {bank_i, vid_addr_i}));

  p_rfsh_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |-> (eff_addr_o[15:8] == 8'h00 && src_o == 2'd2));

  p_row_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!refresh_i && $past(ras_ni)) |-> (dram_ma_o == eff_addr_o[7:0]));

  p_col_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!refresh_i && !$past(ras_ni)) |-> (dram_ma_o == eff_addr_o[15:8]));

  p_rfsh_row_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |-> (dram_ma_o == eff_addr_o[7:0]));

  p_rfsh_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_i && $past(refresh_i) && $past(ras_ni) && !$past(ras_ni, 2))
      |-> (eff_addr_o[7:0] == $past(eff_addr_o[7:0]) + 8'd1));

  p_vdata_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_data_o == {color_data_i, mem_data_i});
endmodule

bind dram_addr_mux dram_addr_mux_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .aec_i        (aec_i),
  .refresh_i    (refresh_i),
  .ras_ni       (ras_ni),
  .cpu_addr_i   (cpu_addr_i),
  .vid_addr_i   (vid_addr_i),
  .bank_i       (bank_i),
  .mem_data_i   (mem_data_i),
  .color_data_i (color_data_i),
  .sys_addr_o   (sys_addr_o),
  .eff_addr_o   (eff_addr_o),
  .src_o        (src_o),
  .dram_ma_o    (dram_ma_o),
  .dec_addr_o   (dec_addr_o),
  .vid_data_o   (vid_data_o)
);

// File: tb/sim_dram_addr_mux.sv
`timescale 1ns/1ps
module sim_dram_addr_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aec = 1'b1;
  logic        rfsh = 1'b0;
  logic        ras_n = 1'b1;
  logic [15:0] cpu_a = '0;
  logic [13:0] vid_a = '0;
  logic [1:0]  bank = '0;
  logic [7:0]  mdat = '0;
  logic [3:0]  cdat = '0;
  logic [15:0] sys_a, eff_a, dec_a;
  logic [1:0]  src;
  logic [7:0]  ma;
  logic [11:0] vdat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dram_addr_mux u0 (
    .clk_i(clk), .rst_ni(rst_n), .aec_i(aec), .refresh_i(rfsh), .ras_ni(ras_n),
    .cpu_addr_i(cpu_a), .vid_addr_i(vid_a), .bank_i(bank),
    .mem_data_i(mdat), .color_data_i(cdat),
    .sys_addr_o(sys_a), .eff_addr_o(eff_a), .src_o(src), .dram_ma_o(ma),
    .dec_addr_o(dec_a), .vid_data_o(vdat)
  );

  typedef struct packed {
    logic        aec;
    logic [15:0] cpu;
    logic [13:0] vid;
    logic [1:0]  bank;
    logic [15:0] eff;
    logic [15:0] sys;
    logic [1:0]  src;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 16'h1234, 14'h0000, 2'd0, 16'h1234, 16'h1234, 2'd0},
    '{1'b1, 16'hFFFF, 14'h3FFF, 2'd3, 16'hFFFF, 16'hFFFF, 2'd0},
    '{1'b0, 16'h1234, 14'h3ABC, 2'd2, 16'hBABC, 16'hFABC, 2'd1},
    '{1'b0, 16'h0000, 14'h0000, 2'd0, 16'h0000, 16'hF000, 2'd1},
    '{1'b0, 16'hABCD, 14'h1123, 2'd1, 16'h5123, 16'hF123, 2'd1},
    '{1'b0, 16'h0F0F, 14'h2D00, 2'd3, 16'hED00, 16'hFD00, 2'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ras_pulse();
    @(negedge clk) ras_n = 1'b0;
    @(negedge clk);
    @(negedge clk) ras_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state, row phase, counter zero
    chk("R10 row phase", {24'h0, ma}, 32'h34 & 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rfsh = 1'b1; #1;
    chk("R10 counter zero", {16'h0, eff_a}, 32'h0);
    rfsh = 1'b0;

    // R1 R2 R3 R6 table walk, strobe high so row phase
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      aec = TBL[i].aec; cpu_a = TBL[i].cpu; vid_a = TBL[i].vid; bank = TBL[i].bank;
      #1;
      chk(TBL[i].aec ? "R1 eff" : "R2 eff", {16'h0, eff_a}, {16'h0, TBL[i].eff});
      chk(TBL[i].aec ? "R1 src" : "R2 src", {30'h0, src}, {30'h0, TBL[i].src});
      chk(TBL[i].aec ? "R1 sys" : "R3 sys", {16'h0, sys_a}, {16'h0, TBL[i].sys});
      chk("R6 row", {24'h0, ma}, {24'h0, TBL[i].eff[7:0]});
    end

    // R4: character ROM window visible on decoder address while system bus shows 0xF000
    @(negedge clk);
    aec = 1'b0; vid_a = 14'h1000; bank = 2'd0; cpu_a = 16'h8000; #1;
    chk("R4 dec", {16'h0, dec_a}, 32'h1000);
    chk("R3 sys", {16'h0, sys_a}, 32'hF000);
    aec = 1'b1; #1;
    chk("R1 dec", {16'h0, dec_a}, 32'h8000);

    // R6: column exactly one edge after strobe falls
    @(negedge clk);
    aec = 1'b0; vid_a = 14'h3ABC; bank = 2'd2;
    ras_n = 1'b0; #1;
    chk("R6 row before edge", {24'h0, ma}, 32'hBC);
    @(negedge clk); #1;
    chk("R6 column", {24'h0, ma}, 32'hBA);
    ras_n = 1'b1; #0.5;
    chk("R6 column held", {24'h0, ma}, 32'hBA);
    @(negedge clk); #1;
    chk("R6 back to row", {24'h0, ma}, 32'hBC);

    // R9: data join
    mdat = 8'hA5; cdat = 4'h3; #1;
    chk("R9 vdata", {20'h0, vdat}, 32'h3A5);
    mdat = 8'h0F; cdat = 4'hC; #1;
    chk("R9 vdata", {20'h0, vdat}, 32'hC0F);

    // R5 R7 R8: refresh
    @(negedge clk);
    rfsh = 1'b1; aec = 1'b0; bank = 2'd3; vid_a = 14'h3FFF; #1;
    chk("R5 src", {30'h0, src}, 32'd2);
    chk("R5 eff", {16'h0, eff_a}, 32'h0000);
    bank = 2'd1; #1;
    chk("R5 bank ignored", {16'h0, eff_a}, 32'h0000);
    @(negedge clk) ras_n = 1'b0;
    @(negedge clk); #1;
    chk("R7 row held in refresh", {24'h0, ma}, 32'h00);
    @(negedge clk) ras_n = 1'b1;
    @(negedge clk); #1;
    chk("R8 step", {24'h0, ma}, 32'h01);
    for (int k = 1; k < 255; k++) ras_pulse();
    #1;
    chk("R8 at 255", {16'h0, eff_a}, 32'h00FF);
    ras_pulse(); #1;
    chk("R8 wrap", {16'h0, eff_a}, 32'h0000);
    // no step without refresh
    rfsh = 1'b0;
    ras_pulse();
    rfsh = 1'b1; #1;
    chk("R8 hold when not refresh", {16'h0, eff_a}, 32'h0000);

    // R10: reset clears counter
    ras_pulse(); #1;
    chk("R8 step again", {16'h0, eff_a}, 32'h0001);
    rst_n = 1'b0; #1;
    chk("R10 reset clears", {16'h0, eff_a}, 32'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule